// File: doc/BRIEF.md
# Word/Byte Integer ALU with Condition Codes

This block is the execution stage for the integer two-operand and one-operand operations of a 16-bit processor. Each cycle in which `inValid` is high it takes a source value, a destination value, an operation code, a byte/word select and the current N, Z, V and C flags. On the next clock edge it presents the result, a write-back strobe and the updated flags. Operand fetch, addressing, multiply/divide and floating point are handled elsewhere.

Several operations (compare, bit test, test) only produce flags and never assert the write-back strobe. Rotates pass through the carry flag. When the byte select is high, most operations work on the low 8 bits: N and C are taken at bit 7, and the upper byte of the result is the destination's upper byte. A few operation codes always work on the full word. On the add code, the byte select instead turns the operation into a word subtract.

Top module: `aluFlagUnit`

## Requirements
- R1: While `rstN` is low, `outValid`, `writeEn`, `result` and `flagsOut` are all zero. Flag vectors are packed as {N,Z,V,C} in bits 3..0.
- R2: `outValid` equals the `inValid` of the previous cycle. `writeEn` is high only together with `outValid`. Results of an operation appear at the first rising edge after it is presented. Operation codes: 0 move, 1 compare, 2 bit test, 3 bit clear, 4 bit set, 5 add/subtract, 6 swap bytes, 7 clear, 8 complement, 9 increment, 10 decrement, 11 negate, 12 add carry, 13 subtract carry, 14 test, 15 rotate right, 16 rotate left, 17 shift right, 18 shift left, 19 sign extend.
- R3: Compare (code 1) computes source minus destination, with V set on signed overflow and C set on unsigned borrow. Bit test (code 2) ANDs the operands, clears V and keeps C. Neither one writes back, and `result` carries the computed value.
- R4: Move copies the source. Bit clear gives destination AND NOT source. Bit set gives source OR destination. All three write back, set N and Z from the result, clear V and keep C.
- R5: Code 5 with byte select low gives destination plus source. With byte select high it gives the full-word destination minus source. V is signed overflow, and C is the carry out for the add or the borrow for the subtract.
- R6: Rotate right puts old C in the top bit and bit 0 in C. Rotate left puts old C in bit 0 and the top bit in C.
- R7: Shift right keeps the sign bit and moves bit 0 into C. Shift left fills bit 0 with zero and moves the top bit into C. For all four shift and rotate codes, V equals N XOR the new C.
- R8: Increment and decrement keep C and set V when the operand was the largest positive or the most negative value. Negate sets V when the result is the most negative value and sets C when the result is non-zero. Add carry adds C and subtract carry subtracts C; in both, the new C and V come from the operand's boundary value together with old C.
- R9: Clear gives zero with flags 0100. Complement inverts every bit, clears V and sets C.
- R10: Swap exchanges the bytes, takes N and Z from the new low byte, and clears V and C. Sign extend writes all ones if N is set and zero otherwise, setting Z to NOT N, clearing V and keeping N and C. Test does not write back and updates only N and Z from the destination.
- R11: With byte select high, all codes except 5, 6 and 19 work on bits 7..0. N, Z, V and C follow the 8-bit value, and result bits 15..8 equal destination bits 15..8. Codes 6 and 19 ignore the byte select.
- R12: Codes 20 to 31 do not write back, leave the flags unchanged and return the destination as `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation presented this cycle |
| opSel | input | 5 | Operation code (see R2) |
| byteMode | input | 1 | Byte width select; subtract select on code 5 |
| srcVal | input | 16 | Source operand |
| dstVal | input | 16 | Destination operand |
| flagsIn | input | 4 | Current {N,Z,V,C} |
| outValid | output | 1 | Registered result is valid |
| result | output | 16 | Registered result value |
| writeEn | output | 1 | Result must be written back |
| flagsOut | output | 4 | Updated {N,Z,V,C} |

## Verification
The bench targets operands at the signed and unsigned boundaries: 7FFF, 8000, FFFF and zero, together with their byte equivalents 7F, 80 and FF. A design that mixes up overflow and carry, or that tests V at the wrong bit, gives the wrong flags on exactly these values. The subtract selected on the add code is driven with a destination whose upper byte is non-zero, so a design that treated it as a byte operation would return a wrong upper byte. Byte-mode rotates and shifts check that C and N come from bit 7 and that the upper byte survives. Swap and sign extend are driven in byte mode to show that they keep their full-word behaviour.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [4:0] {
    OP_MOVE   = 5'd0,
    OP_CMP    = 5'd1,
    OP_BITT   = 5'd2,
    OP_BITC   = 5'd3,
    OP_BITS   = 5'd4,
    OP_ADDSUB = 5'd5,
    OP_SWAP   = 5'd6,
    OP_CLR    = 5'd7,
    OP_COM    = 5'd8,
    OP_INC    = 5'd9,
    OP_DEC    = 5'd10,
    OP_NEG    = 5'd11,
    OP_ADC    = 5'd12,
    OP_SBC    = 5'd13,
    OP_TST    = 5'd14,
    OP_ROR    = 5'd15,
    OP_ROL    = 5'd16,
    OP_ASR    = 5'd17,
    OP_ASL    = 5'd18,
    OP_SXT    = 5'd19
  } aluOp_e;

  typedef enum logic [4:0] {
    FN_NONE, FN_PASS, FN_CMP, FN_AND, FN_BIC, FN_BIS, FN_ADD, FN_SUB,
    FN_SWAP, FN_CLR, FN_COM, FN_INC, FN_DEC, FN_NEG, FN_ADC, FN_SBC,
    FN_TST, FN_ROR, FN_ROL, FN_ASR, FN_ASL, FN_SXT
  } aluFn_e;

  typedef struct packed {
    aluFn_e fn;
    logic   wide;
    logic   wrEn;
  } aluCtrl_t;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [4:0] opSel,
  input  logic       byteMode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.fn   = FN_NONE;
    ctrl.wide = !byteMode;
    ctrl.wrEn = 1'b1;
    case (opSel)
      OP_MOVE: ctrl.fn = FN_PASS;
      OP_CMP: begin
        ctrl.fn   = FN_CMP;
        ctrl.wrEn = 1'b0;
      end
      OP_BITT: begin
        ctrl.fn   = FN_AND;
        ctrl.wrEn = 1'b0;
      end
      OP_BITC: ctrl.fn = FN_BIC;
      OP_BITS: ctrl.fn = FN_BIS;
      OP_ADDSUB: begin
        // byte select means subtract here, never a narrow width
        ctrl.fn   = byteMode ? FN_SUB : FN_ADD;
        ctrl.wide = 1'b1;
      end
      OP_SWAP: begin
        ctrl.fn   = FN_SWAP;
        ctrl.wide = 1'b1;
      end
      OP_CLR: ctrl.fn = FN_CLR;
      OP_COM: ctrl.fn = FN_COM;
      OP_INC: ctrl.fn = FN_INC;
      OP_DEC: ctrl.fn = FN_DEC;
      OP_NEG: ctrl.fn = FN_NEG;
      OP_ADC: ctrl.fn = FN_ADC;
      OP_SBC: ctrl.fn = FN_SBC;
      OP_TST: begin
        ctrl.fn   = FN_TST;
        ctrl.wrEn = 1'b0;
      end
      OP_ROR: ctrl.fn = FN_ROR;
      OP_ROL: ctrl.fn = FN_ROL;
      OP_ASR: ctrl.fn = FN_ASR;
      OP_ASL: ctrl.fn = FN_ASL;
      OP_SXT: begin
        ctrl.fn   = FN_SXT;
        ctrl.wide = 1'b1;
      end
      default: begin
        ctrl.fn   = FN_NONE;
        ctrl.wrEn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int W = 16
) (
  input  aluFn_e       fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   flagsIn,
  output logic [W-1:0] res,
  output logic [3:0]   flags
);

  localparam int MSB = W - 1;
  localparam int HW  = W / 2;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXP = ~MINV;
  localparam logic [W-1:0] ALL1 = '1;

  logic         nIn, zIn, vIn, cIn;
  logic         nzUpd, v, c;
  logic [W:0]   ext;
  logic [W-1:0] cExt;

  assign nIn  = flagsIn[FLG_N];
  assign zIn  = flagsIn[FLG_Z];
  assign vIn  = flagsIn[FLG_V];
  assign cIn  = flagsIn[FLG_C];
  assign cExt = {{(W-1){1'b0}}, cIn};

  always_comb begin
    res   = b;
    nzUpd = 1'b1;
    v     = vIn;
    c     = cIn;
    ext   = '0;
    case (fn)
      FN_PASS: begin
        res = a;
        v   = 1'b0;
      end
      FN_CMP: begin
        ext = {1'b0, a} - {1'b0, b};
        res = ext[W-1:0];
        c   = ext[W];
        v   = (a[MSB] ^ b[MSB]) & (ext[MSB] ^ a[MSB]);
      end
      FN_AND: begin
        res = a & b;
        v   = 1'b0;
      end
      FN_BIC: begin
        res = ~a & b;
        v   = 1'b0;
      end
      FN_BIS: begin
        res = a | b;
        v   = 1'b0;
      end
      FN_ADD: begin
        ext = {1'b0, b} + {1'b0, a};
        res = ext[W-1:0];
        c   = ext[W];
        v   = ~(a[MSB] ^ b[MSB]) & (ext[MSB] ^ b[MSB]);
      end
      FN_SUB: begin
        ext = {1'b0, b} - {1'b0, a};
        res = ext[W-1:0];
        c   = ext[W];
        v   = (a[MSB] ^ b[MSB]) & (ext[MSB] ^ b[MSB]);
      end
      FN_SWAP: begin
        res = {b[HW-1:0], b[W-1:HW]};
        v   = 1'b0;
        c   = 1'b0;
      end
      FN_CLR: begin
        res = '0;
        v   = 1'b0;
        c   = 1'b0;
      end
      FN_COM: begin
        res = ~b;
        v   = 1'b0;
        c   = 1'b1;
      end
      FN_INC: begin
        res = b + ONE;
        v   = (b == MAXP);
      end
      FN_DEC: begin
        res = b - ONE;
        v   = (b == MINV);
      end
      FN_NEG: begin
        res = ~b + ONE;
        v   = (b == MINV);
        c   = (b != '0);
      end
      FN_ADC: begin
        res = b + cExt;
        v   = cIn & (b == MAXP);
        c   = cIn & (b == ALL1);
      end
      FN_SBC: begin
        res = b - cExt;
        v   = cIn & (b == MINV);
        c   = cIn & (b == '0);
      end
      FN_TST: res = b;
      FN_ROR: begin
        res = {cIn, b[MSB:1]};
        c   = b[0];
        v   = cIn ^ b[0];
      end
      FN_ROL: begin
        res = {b[MSB-1:0], cIn};
        c   = b[MSB];
        v   = b[MSB-1] ^ b[MSB];
      end
      FN_ASR: begin
        res = {b[MSB], b[MSB:1]};
        c   = b[0];
        v   = b[MSB] ^ b[0];
      end
      FN_ASL: begin
        res = {b[MSB-1:0], 1'b0};
        c   = b[MSB];
        v   = b[MSB-1] ^ b[MSB];
      end
      FN_SXT: begin
        res = {W{nIn}};
        v   = 1'b0;
      end
      default: begin
        res   = b;
        nzUpd = 1'b0;
      end
    endcase
  end

  always_comb begin
    flags[FLG_N] = nzUpd ? res[MSB] : nIn;
    flags[FLG_Z] = nzUpd ? (res == '0) : zIn;
    flags[FLG_V] = v;
    flags[FLG_C] = c;
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flagsOut
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] wordRes, nextRes;
  logic [HALF-1:0]   byteRes;
  logic [3:0]        wordFlg, byteFlg, nextFlg;

  aluCore #(.W(DATA_W)) wordCore (
    .fn(ctrl.fn), .a(srcVal), .b(dstVal), .flagsIn(flagsIn),
    .res(wordRes), .flags(wordFlg)
  );

  aluCore #(.W(HALF)) byteCore (
    .fn(ctrl.fn), .a(srcVal[HALF-1:0]), .b(dstVal[HALF-1:0]),
    .flagsIn(flagsIn), .res(byteRes), .flags(byteFlg)
  );

  always_comb begin
    if (ctrl.wide) begin
      nextRes = wordRes;
      nextFlg = wordFlg;
      if (ctrl.fn == FN_SWAP) begin
        // swapped word reports N and Z from its new low byte
        nextFlg[FLG_N] = wordRes[HALF-1];
        nextFlg[FLG_Z] = (wordRes[HALF-1:0] == '0);
      end
    end else begin
      nextRes = {dstVal[DATA_W-1:HALF], byteRes};
      nextFlg = byteFlg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      writeEn  <= 1'b0;
      result   <= '0;
      flagsOut <= '0;
    end else if (inValid) begin
      outValid <= 1'b1;
      writeEn  <= ctrl.wrEn;
      result   <= nextRes;
      flagsOut <= nextFlg;
    end else begin
      outValid <= 1'b0;
      writeEn  <= 1'b0;
    end
  end

endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [4:0]        opSel,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flagsOut
);

  aluCtrl_t ctrl;

  aluCtrl ctrlUnit (
    .opSel(opSel), .byteMode(byteMode), .ctrl(ctrl)
  );

  aluDatapath #(.DATA_W(DATA_W)) dataUnit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl),
    .srcVal(srcVal), .dstVal(dstVal), .flagsIn(flagsIn),
    .outValid(outValid), .result(result), .writeEn(writeEn),
    .flagsOut(flagsOut)
  );

endmodule

// File: rtl/aluFlagUnitChk.sv
module aluFlagUnitChk
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [4:0]               opSel,
  input logic                     byteMode,
  input logic [DATA_W-1:DATA_W/2] dstHi,
  input logic                     outValid,
  input logic [DATA_W-1:DATA_W/2] resultHi,
  input logic                     writeEn,
  input logic [3:0]               flagsOut
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outValid == $past(inValid)));

  // R2
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> outValid);

  // R3
  flag_only_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == OP_CMP || opSel == OP_BITT || opSel == OP_TST))
    |=> !writeEn);

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_CLR) |=> (flagsOut == 4'b0100));

  // R7
  shift_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == OP_ROR || opSel == OP_ROL ||
                 opSel == OP_ASR || opSel == OP_ASL))
    |=> (flagsOut[FLG_V] == (flagsOut[FLG_N] ^ flagsOut[FLG_C])));

  // R11
  byte_upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && byteMode && opSel != OP_ADDSUB && opSel != OP_SWAP &&
     opSel != OP_SXT) |=> (resultHi == $past(dstHi)));

endmodule

bind aluFlagUnit aluFlagUnitChk #(.DATA_W(DATA_W)) chkInst (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
  .byteMode(byteMode), .dstHi(dstVal[DATA_W-1:DATA_W/2]),
  .outValid(outValid), .resultHi(result[DATA_W-1:DATA_W/2]),
  .writeEn(writeEn), .flagsOut(flagsOut)
);

// File: tb/aluFlagUnit_test.sv
module aluFlagUnit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;

  typedef struct packed {
    logic [4:0]  op;
    logic        byteM;
    logic [15:0] src;
    logic [15:0] dst;
    logic [3:0]  fin;
    logic [15:0] expRes;
    logic        expWr;
    logic [3:0]  expFlg;
    logic [7:0]  req;
  } vec_t;

  // flags packed {N,Z,V,C}
  localparam vec_t VECS [NV] = '{
    '{5'd0,  1'b0, 16'h8000, 16'h1234, 4'h1, 16'h8000, 1'b1, 4'h9, 8'd4},  // R4 move
    '{5'd0,  1'b1, 16'h0000, 16'hABCD, 4'h2, 16'hAB00, 1'b1, 4'h4, 8'd11}, // R11 byte move
    '{5'd1,  1'b0, 16'h0003, 16'h0005, 4'h0, 16'hFFFE, 1'b0, 4'h9, 8'd3},  // R3 compare borrow
    '{5'd1,  1'b0, 16'h8000, 16'h0001, 4'h0, 16'h7FFF, 1'b0, 4'h2, 8'd3},  // R3 compare overflow
    '{5'd2,  1'b0, 16'h00F0, 16'h0F0F, 4'h1, 16'h0000, 1'b0, 4'h5, 8'd3},  // R3 bit test
    '{5'd3,  1'b0, 16'h00FF, 16'h1234, 4'h2, 16'h1200, 1'b1, 4'h0, 8'd4},  // R4 bit clear
    '{5'd4,  1'b0, 16'h8001, 16'h0100, 4'h1, 16'h8101, 1'b1, 4'h9, 8'd4},  // R4 bit set
    '{5'd5,  1'b0, 16'h7FFF, 16'h0001, 4'h0, 16'h8000, 1'b1, 4'hA, 8'd5},  // R5 add overflow
    '{5'd5,  1'b0, 16'hFFFF, 16'h0001, 4'h0, 16'h0000, 1'b1, 4'h5, 8'd5},  // R5 add carry
    '{5'd5,  1'b1, 16'h0001, 16'h0100, 4'h0, 16'h00FF, 1'b1, 4'h0, 8'd5},  // R5 word subtract
    '{5'd5,  1'b1, 16'h0001, 16'h8000, 4'h0, 16'h7FFF, 1'b1, 4'h2, 8'd5},  // R5 subtract overflow
    '{5'd6,  1'b0, 16'h0000, 16'h8012, 4'hF, 16'h1280, 1'b1, 4'h8, 8'd10}, // R10 swap
    '{5'd7,  1'b0, 16'h0000, 16'hFFFF, 4'hB, 16'h0000, 1'b1, 4'h4, 8'd9},  // R9 clear
    '{5'd8,  1'b0, 16'h0000, 16'h00FF, 4'h0, 16'hFF00, 1'b1, 4'h9, 8'd9},  // R9 complement
    '{5'd9,  1'b0, 16'h0000, 16'h7FFF, 4'h1, 16'h8000, 1'b1, 4'hB, 8'd8},  // R8 increment
    '{5'd10, 1'b0, 16'h0000, 16'h8000, 4'h0, 16'h7FFF, 1'b1, 4'h2, 8'd8},  // R8 decrement
    '{5'd11, 1'b0, 16'h0000, 16'h0001, 4'h0, 16'hFFFF, 1'b1, 4'h9, 8'd8},  // R8 negate
    '{5'd11, 1'b0, 16'h0000, 16'h0000, 4'h0, 16'h0000, 1'b1, 4'h4, 8'd8},  // R8 negate zero
    '{5'd11, 1'b0, 16'h0000, 16'h8000, 4'h0, 16'h8000, 1'b1, 4'hB, 8'd8},  // R8 negate min
    '{5'd12, 1'b0, 16'h0000, 16'hFFFF, 4'h1, 16'h0000, 1'b1, 4'h5, 8'd8},  // R8 add carry
    '{5'd13, 1'b0, 16'h0000, 16'h0000, 4'h1, 16'hFFFF, 1'b1, 4'h9, 8'd8},  // R8 subtract carry
    '{5'd14, 1'b0, 16'h0000, 16'h8000, 4'h3, 16'h8000, 1'b0, 4'hB, 8'd10}, // R10 test
    '{5'd15, 1'b0, 16'h0000, 16'h0001, 4'h0, 16'h0000, 1'b1, 4'h7, 8'd6},  // R6 rotate right
    '{5'd15, 1'b0, 16'h0000, 16'h0002, 4'h1, 16'h8001, 1'b1, 4'hA, 8'd6},  // R6 rotate right C in
    '{5'd16, 1'b0, 16'h0000, 16'h8000, 4'h1, 16'h0001, 1'b1, 4'h3, 8'd6},  // R6 rotate left
    '{5'd17, 1'b0, 16'h0000, 16'h8003, 4'h0, 16'hC001, 1'b1, 4'h9, 8'd7},  // R7 shift right
    '{5'd18, 1'b0, 16'h0000, 16'h4000, 4'h1, 16'h8000, 1'b1, 4'hA, 8'd7},  // R7 shift left
    '{5'd19, 1'b0, 16'h0000, 16'h1234, 4'h9, 16'hFFFF, 1'b1, 4'h9, 8'd10}, // R10 sign extend N
    '{5'd19, 1'b0, 16'h0000, 16'h1234, 4'h7, 16'h0000, 1'b1, 4'h5, 8'd10}, // R10 sign extend
    '{5'd9,  1'b1, 16'h0000, 16'h127F, 4'h0, 16'h1280, 1'b1, 4'hA, 8'd11}, // R11 byte increment
    '{5'd1,  1'b1, 16'h0080, 16'h0001, 4'h0, 16'h007F, 1'b0, 4'h2, 8'd11}, // R11 byte compare
    '{5'd16, 1'b1, 16'h0000, 16'h3480, 4'h0, 16'h3400, 1'b1, 4'h7, 8'd11}, // R11 byte rotate left
    '{5'd17, 1'b1, 16'h0000, 16'hFF81, 4'h0, 16'hFFC0, 1'b1, 4'h9, 8'd11}, // R11 byte shift right
    '{5'd19, 1'b1, 16'h0000, 16'h0000, 4'h8, 16'hFFFF, 1'b1, 4'h8, 8'd11}, // R11 sign extend word
    '{5'd6,  1'b1, 16'h0000, 16'h8012, 4'h0, 16'h1280, 1'b1, 4'h8, 8'd11}, // R11 swap word
    '{5'd11, 1'b1, 16'h0000, 16'hAA80, 4'h0, 16'hAA80, 1'b1, 4'hB, 8'd11}, // R11 byte negate
    '{5'd12, 1'b1, 16'h0000, 16'h00FF, 4'h1, 16'h0000, 1'b1, 4'h5, 8'd11}, // R11 byte add carry
    '{5'd7,  1'b1, 16'h0000, 16'hABCD, 4'h3, 16'hAB00, 1'b1, 4'h4, 8'd11}, // R11 byte clear
    '{5'd25, 1'b0, 16'h0001, 16'hABCD, 4'hA, 16'hABCD, 1'b0, 4'hA, 8'd12}, // R12 unused
    '{5'd31, 1'b1, 16'hFFFF, 16'h5555, 4'h5, 16'h5555, 1'b0, 4'h5, 8'd12}  // R12 unused byte
  };

  logic        clk;
  logic        rstN;
  logic        inValid;
  logic [4:0]  opSel;
  logic        byteMode;
  logic [15:0] srcVal, dstVal;
  logic [3:0]  flagsIn;
  logic        outValid, writeEn;
  logic [15:0] result;
  logic [3:0]  flagsOut;

  int checks;
  int fails;
  bit done;

  aluFlagUnit #(.DATA_W(16)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .byteMode(byteMode), .srcVal(srcVal), .dstVal(dstVal),
    .flagsIn(flagsIn), .outValid(outValid), .result(result),
    .writeEn(writeEn), .flagsOut(flagsOut)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    inValid  = 1'b1;
    opSel    = v.op;
    byteMode = v.byteM;
    srcVal   = v.src;
    dstVal   = v.dst;
    flagsIn  = v.fin;
  endtask

  initial begin
    logic [31:0] act, exp;
    checks = 0;
    fails = 0;
    done = 1'b0;
    rstN = 1'b0;
    inValid = 1'b0;
    opSel = '0;
    byteMode = 1'b0;
    srcVal = '0;
    dstVal = '0;
    flagsIn = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 reset state", {outValid, writeEn, result, flagsOut} == '0,
          {10'd0, outValid, writeEn, result, flagsOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: idle cycle after reset
    check("R2 idle", !outValid && !writeEn,
          {30'd0, outValid, writeEn}, 32'd0);

    // vector table, back to back
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      act = {10'd0, outValid, result, writeEn, flagsOut};
      exp = {10'd0, 1'b1, VECS[i].expRes, VECS[i].expWr, VECS[i].expFlg};
      checks++;
      if (act != exp) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h",
                 VECS[i].req, i, act, exp);
      end
    end

    // R2: valid drops, outputs report no operation
    inValid = 1'b0;
    @(negedge clk);
    check("R2 valid drop", !outValid && !writeEn,
          {30'd0, outValid, writeEn}, 32'd0);

    // R2: one-cycle latency, nothing before the edge
    apply(VECS[7]);
    #1;
    check("R2 latency before edge", !outValid,
          {31'd0, outValid}, 32'd0);
    @(negedge clk);
    check("R2 latency after edge", outValid && result == 16'h8000,
          {15'd0, outValid, result}, {15'd0, 1'b1, 16'h8000});

    // R1: reset in mid-run clears a writing result
    apply(VECS[0]);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-run", {outValid, writeEn, result, flagsOut} == '0,
          {10'd0, outValid, writeEn, result, flagsOut}, 32'd0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule